// File: doc/BRIEF.md
# Receiver-Enable Delay Seed Calculator

This block prepares and finishes the receiver-enable timing for the byte lanes of one memory channel. Before hardware-assisted training, each lane's seed is formed from its write-leveling strobe delay plus a platform estimate. A per-lane override replaces that estimate when it is present. The seed is split into a gross part, counted in 32-step units, and a fine remainder. A pre-gross value chosen by the parity of the gross part goes to the PHY as the training start point. The gap between gross and pre-gross is kept in a per-lane store.

After the PHY has trained, the caller streams each lane's trained readback through the finalize port. The block restores the stored gross gap, adds one unit interval (32 steps) so the enable lands mid-preamble, and returns the final delay. It also keeps the largest final delay seen since the pass began, which sets the maximum read latency. Both passes take one lane per cycle, and each result comes out on the next cycle.

Top module: `rxen_seed_calc`

## Requirements
- R1: The seed total is wr_dqs_dly plus the chosen estimate, computed on 10 bits and clamped to 1023 rather than wrapping.
- R2: When plat_ovr_en is 1, plat_ovr is used in place of plat_est; when it is 0, plat_ovr has no effect on any output.
- R3: With gross = total[9:5] and fine = total[4:0], rcven_init equals gross shifted left by 5 (bits 4:0 zero).
- R4: Pre-gross is 1 when gross is odd and 2 when gross is even; phy_seed equals pre-gross shifted left by 5 ORed with fine.
- R5: gross_diff equals (gross minus pre-gross) shifted left by 5, or 0 when gross is smaller than pre-gross (gross = 0), and is stored for the lane seed_lane.
- R6: A seed request on seed_vld produces seed_out_vld, seed_out_lane and the seed values on the following cycle only.
- R7: A finalize request produces, one cycle later, fin_out_vld, fin_out_lane and final_dly = phy_rdbk + (stored difference AND 0x1E0) + 0x20.
- R8: final_dly is clamped to 1023 when that sum exceeds 10 bits.
- R9: max_dly is the largest final_dly since the last fin_start; fin_start alone sets it to 0 on the next cycle, and fin_start together with fin_vld starts the new maximum from that lane's result.
- R10: After reset, seed_out_vld, fin_out_vld and max_dly are 0 and every lane's stored difference is 0, so an unseeded lane finalizes to phy_rdbk + 0x20.
- R11: Seeding one lane leaves the stored differences of all other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_vld | input | 1 | Seed request for one lane |
| seed_lane | input | 3 | Lane index of the seed request |
| wr_dqs_dly | input | 10 | Write-leveling strobe delay of the lane |
| plat_est | input | 10 | Default platform estimate |
| plat_ovr_en | input | 1 | Use the per-lane override estimate |
| plat_ovr | input | 10 | Per-lane override estimate |
| seed_out_vld | output | 1 | Seed results valid |
| seed_out_lane | output | 3 | Lane of the seed results |
| phy_seed | output | 10 | Pre-gross and fine start value for the PHY |
| rcven_init | output | 10 | Initial receiver-enable delay (gross only) |
| gross_diff | output | 10 | Gross minus pre-gross, in delay steps |
| fin_start | input | 1 | Begin a finalize pass (clears the maximum) |
| fin_vld | input | 1 | Finalize request for one lane |
| fin_lane | input | 3 | Lane index of the finalize request |
| phy_rdbk | input | 10 | Trained delay read back from the PHY |
| fin_out_vld | output | 1 | Final delay valid |
| fin_out_lane | output | 3 | Lane of the final delay |
| final_dly | output | 10 | Final receiver-enable delay |
| max_dly | output | 10 | Largest final delay in the current pass |

## Verification
Every seed result and every final delay is due exactly one rising edge after its request, and max_dly changes on that same edge. The driver applies each request on a falling edge and pushes the expected values into a queue. The monitor samples on the next falling edge, so it looks at outputs that settled half a cycle earlier. A valid output with nothing queued, or a queue left non-empty at the end, counts as a failure, which catches results that come too late, too early or twice. The clear by fin_start alone is checked directly on the falling edge after the pulse.

// File: rtl/rxen_seed_pkg.sv
package rxen_seed_pkg;
   // Behaviour of additions that exceed the delay width
   typedef enum int unsigned {
      OVF_SAT  = 0,
      OVF_WRAP = 1
   } ovf_mode_e;
endpackage

// File: rtl/rxen_seed_split.sv
module rxen_seed_split
   import rxen_seed_pkg::*;
#(
   parameter int        DLY_W    = 10,
   parameter int        FINE_W   = 5,
   parameter ovf_mode_e OVF_MODE = OVF_SAT
) (
   input  logic [DLY_W-1:0] wr_dly,
   input  logic [DLY_W-1:0] est,
   input  logic             ovr_en,
   input  logic [DLY_W-1:0] ovr,
   output logic [DLY_W-1:0] phy_seed,
   output logic [DLY_W-1:0] init_dly,
   output logic [DLY_W-1:0] diff
);
   localparam int GROSS_W = DLY_W - FINE_W;

   logic [DLY_W:0]         raw;
   logic [DLY_W-1:0]       total;
   logic [GROSS_W-1:0]     gross;
   logic [GROSS_W-1:0]     pre_gross;
   logic [GROSS_W-1:0]     gap;
   logic [FINE_W-1:0]      fine;

   assign raw = {1'b0, wr_dly} + {1'b0, (ovr_en ? ovr : est)};

   generate
      if (OVF_MODE == OVF_SAT) begin : g_sat
         assign total = raw[DLY_W] ? {DLY_W{1'b1}} : raw[DLY_W-1:0];
      end else begin : g_wrap
         logic unused_carry;
         assign unused_carry = raw[DLY_W];
         assign total        = raw[DLY_W-1:0];
      end
   endgenerate

   assign gross     = total[DLY_W-1:FINE_W];
   assign fine      = total[FINE_W-1:0];
   assign pre_gross = gross[0] ? GROSS_W'(1) : GROSS_W'(2);
   assign gap       = (gross >= pre_gross) ? (gross - pre_gross) : '0;

   assign phy_seed = {pre_gross, fine};
   assign init_dly = {gross, {FINE_W{1'b0}}};
   assign diff     = {gap, {FINE_W{1'b0}}};
endmodule

// File: rtl/rxen_final_calc.sv
module rxen_final_calc
   import rxen_seed_pkg::*;
#(
   parameter int        DLY_W    = 10,
   parameter int        FINE_W   = 5,
   parameter int        KEEP_W   = 4,
   parameter ovf_mode_e OVF_MODE = OVF_SAT
) (
   input  logic [DLY_W-1:0] rdbk,
   input  logic [DLY_W-1:0] stored,
   output logic [DLY_W-1:0] final_dly
);
   localparam int SUM_W = DLY_W + 2;
   localparam logic [SUM_W-1:0] UI_STEPS = SUM_W'(1) << FINE_W;

   logic [KEEP_W-1:0]  kept;
   logic [SUM_W-1:0]   sum;
   logic               unused_stored;

   // Only the masked window of the stored difference is restored
   assign kept          = stored[FINE_W+KEEP_W-1:FINE_W];
   assign unused_stored = ^{stored[DLY_W-1:FINE_W+KEEP_W], stored[FINE_W-1:0]};
   assign sum           = SUM_W'(rdbk) + (SUM_W'(kept) << FINE_W) + UI_STEPS;

   generate
      if (OVF_MODE == OVF_SAT) begin : g_sat
         assign final_dly = (|sum[SUM_W-1:DLY_W]) ? {DLY_W{1'b1}} : sum[DLY_W-1:0];
      end else begin : g_wrap
         logic unused_hi;
         assign unused_hi = |sum[SUM_W-1:DLY_W];
         assign final_dly = sum[DLY_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rxen_lane_store.sv
module rxen_lane_store #(
   parameter int NUM_LANES = 8,
   parameter int DLY_W     = 10,
   parameter int LANE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [DLY_W-1:0]  wr_val,
   input  logic [LANE_W-1:0] rd_lane,
   output logic [DLY_W-1:0]  rd_val
);
   logic [DLY_W-1:0] slot [NUM_LANES];

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot[i] <= '0;
            end else if (wr_en && (wr_lane == LANE_W'(i))) begin
               slot[i] <= wr_val;
            end
         end

         // A lane not addressed by a write keeps its value
         assert_lane_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_lane == LANE_W'(i))) |=> $stable(slot[i]));
      end
   endgenerate

   assign rd_val = slot[rd_lane];
endmodule

// File: rtl/rxen_seed_calc.sv
module rxen_seed_calc
   import rxen_seed_pkg::*;
#(
   parameter int        NUM_LANES = 8,
   parameter int        DLY_W     = 10,
   parameter int        FINE_W    = 5,
   parameter int        KEEP_W    = 4,
   parameter ovf_mode_e OVF_MODE  = OVF_SAT,
   localparam int       LANE_W    = $clog2(NUM_LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_vld,
   input  logic [LANE_W-1:0] seed_lane,
   input  logic [DLY_W-1:0]  wr_dqs_dly,
   input  logic [DLY_W-1:0]  plat_est,
   input  logic              plat_ovr_en,
   input  logic [DLY_W-1:0]  plat_ovr,
   output logic              seed_out_vld,
   output logic [LANE_W-1:0] seed_out_lane,
   output logic [DLY_W-1:0]  phy_seed,
   output logic [DLY_W-1:0]  rcven_init,
   output logic [DLY_W-1:0]  gross_diff,
   input  logic              fin_start,
   input  logic              fin_vld,
   input  logic [LANE_W-1:0] fin_lane,
   input  logic [DLY_W-1:0]  phy_rdbk,
   output logic              fin_out_vld,
   output logic [LANE_W-1:0] fin_out_lane,
   output logic [DLY_W-1:0]  final_dly,
   output logic [DLY_W-1:0]  max_dly
);
   localparam int GROSS_W = DLY_W - FINE_W;
   localparam logic [DLY_W-1:0] UI_STEPS = DLY_W'(1) << FINE_W;

   // Elaboration-time parameter checks
   generate
      if (NUM_LANES < 2) begin : g_chk_lanes
         $error("NUM_LANES must be at least 2");
      end
      if (GROSS_W < 2) begin : g_chk_gross
         $error("gross field must hold the value 2");
      end
      if (FINE_W + KEEP_W > DLY_W) begin : g_chk_keep
         $error("kept difference window exceeds the delay width");
      end
   endgenerate

   logic [DLY_W-1:0] seed_c, init_c, diff_c;
   logic [DLY_W-1:0] stored_c, final_c, max_base;

   rxen_seed_split #(
      .DLY_W(DLY_W), .FINE_W(FINE_W), .OVF_MODE(OVF_MODE)
   ) u_split (
      .wr_dly(wr_dqs_dly), .est(plat_est), .ovr_en(plat_ovr_en), .ovr(plat_ovr),
      .phy_seed(seed_c), .init_dly(init_c), .diff(diff_c)
   );

   rxen_lane_store #(
      .NUM_LANES(NUM_LANES), .DLY_W(DLY_W), .LANE_W(LANE_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(seed_vld), .wr_lane(seed_lane), .wr_val(diff_c),
      .rd_lane(fin_lane), .rd_val(stored_c)
   );

   rxen_final_calc #(
      .DLY_W(DLY_W), .FINE_W(FINE_W), .KEEP_W(KEEP_W), .OVF_MODE(OVF_MODE)
   ) u_final (
      .rdbk(phy_rdbk), .stored(stored_c), .final_dly(final_c)
   );

   assign max_base = fin_start ? '0 : max_dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_out_vld  <= 1'b0;
         seed_out_lane <= '0;
         phy_seed      <= '0;
         rcven_init    <= '0;
         gross_diff    <= '0;
      end else begin
         seed_out_vld <= seed_vld;
         if (seed_vld) begin
            seed_out_lane <= seed_lane;
            phy_seed      <= seed_c;
            rcven_init    <= init_c;
            gross_diff    <= diff_c;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fin_out_vld  <= 1'b0;
         fin_out_lane <= '0;
         final_dly    <= '0;
         max_dly      <= '0;
      end else begin
         fin_out_vld <= fin_vld;
         if (fin_vld) begin
            fin_out_lane <= fin_lane;
            final_dly    <= final_c;
            max_dly      <= (final_c > max_base) ? final_c : max_base;
         end else begin
            max_dly      <= max_base;
         end
      end
   end

   // R6: one-cycle seed latency with the lane carried along
   assert_seed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seed_vld |=> (seed_out_vld && (seed_out_lane == $past(seed_lane))));

   // R4: PHY seed upper field holds 1 for odd gross, 2 for even gross
   assert_pre_gross_R4: assert property (@(posedge clk) disable iff (!rst_n)
      seed_out_vld |-> (phy_seed[DLY_W-1:FINE_W] ==
                        (rcven_init[FINE_W] ? GROSS_W'(1) : GROSS_W'(2))));

   // R5: pre-gross plus stored gap rebuilds the gross part unless floored
   assert_gap_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seed_out_vld |-> ((gross_diff[FINE_W-1:0] == '0) &&
                        ((gross_diff == '0) ||
                         (rcven_init[DLY_W-1:FINE_W] ==
                          phy_seed[DLY_W-1:FINE_W] + gross_diff[DLY_W-1:FINE_W]))));

   // R7: the one-UI correction never lets a final delay fall below one UI
   assert_final_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_out_vld && (OVF_MODE == OVF_SAT)) |-> (final_dly >= UI_STEPS));

   // R9: the reported maximum covers every final delay of the pass
   assert_max_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fin_out_vld |-> (max_dly >= final_dly));

   assert_max_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_start && !fin_vld) |=> (max_dly == '0));
endmodule

// File: tb/test_rxen_seed_calc.sv
module test_rxen_seed_calc;
   localparam int LW = 3;
   localparam int DW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seed_vld = 1'b0;
   logic [LW-1:0] seed_lane = '0;
   logic [DW-1:0] wr_dqs_dly = '0, plat_est = '0, plat_ovr = '0;
   logic          plat_ovr_en = 1'b0;
   logic          seed_out_vld;
   logic [LW-1:0] seed_out_lane;
   logic [DW-1:0] phy_seed, rcven_init, gross_diff;
   logic          fin_start = 1'b0, fin_vld = 1'b0;
   logic [LW-1:0] fin_lane = '0;
   logic [DW-1:0] phy_rdbk = '0;
   logic          fin_out_vld;
   logic [LW-1:0] fin_out_lane;
   logic [DW-1:0] final_dly, max_dly;

   always #5 clk = ~clk;

   rxen_seed_calc i_rxen_seed_calc (
      .clk(clk), .rst_n(rst_n),
      .seed_vld(seed_vld), .seed_lane(seed_lane), .wr_dqs_dly(wr_dqs_dly),
      .plat_est(plat_est), .plat_ovr_en(plat_ovr_en), .plat_ovr(plat_ovr),
      .seed_out_vld(seed_out_vld), .seed_out_lane(seed_out_lane),
      .phy_seed(phy_seed), .rcven_init(rcven_init), .gross_diff(gross_diff),
      .fin_start(fin_start), .fin_vld(fin_vld), .fin_lane(fin_lane),
      .phy_rdbk(phy_rdbk), .fin_out_vld(fin_out_vld), .fin_out_lane(fin_out_lane),
      .final_dly(final_dly), .max_dly(max_dly)
   );

   typedef struct packed {
      logic [LW-1:0] lane;
      logic [DW-1:0] seed;
      logic [DW-1:0] init;
      logic [DW-1:0] diff;
   } seed_exp_t;

   typedef struct packed {
      logic [LW-1:0] lane;
      logic [DW-1:0] fin;
      logic [DW-1:0] mx;
   } fin_exp_t;

   seed_exp_t seed_q[$];
   fin_exp_t  fin_q[$];
   int        model_diff [8];
   int        model_max;
   int        total_checks = 0;
   int        bad_checks = 0;
   bit        finished = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      total_checks++;
      if (act != exp) begin
         bad_checks++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
         $finish;
      end
   endtask

   // Driver: applies one seed request on a falling edge and predicts its results
   task automatic drive_seed(input int lane, input int wr, input int est,
                             input bit oe, input int ov);
      int tot, g, f, pg, d;
      @(negedge clk);
      fin_vld = 1'b0; fin_start = 1'b0;
      seed_vld = 1'b1; seed_lane = LW'(lane); wr_dqs_dly = DW'(wr);
      plat_est = DW'(est); plat_ovr_en = oe; plat_ovr = DW'(ov);
      tot = wr + (oe ? ov : est);                     // R1, R2
      if (tot > 1023) tot = 1023;
      g  = tot / 32;                                  // R3
      f  = tot % 32;
      pg = (g % 2 == 1) ? 1 : 2;                      // R4
      d  = (g >= pg) ? (g - pg) * 32 : 0;             // R5
      model_diff[lane] = d;
      seed_q.push_back('{lane: LW'(lane), seed: DW'(pg * 32 + f),
                         init: DW'(g * 32), diff: DW'(d)});
   endtask

   task automatic drive_fin(input int lane, input int rd, input bit st);
      int fv, base;
      @(negedge clk);
      seed_vld = 1'b0;
      fin_vld = 1'b1; fin_start = st; fin_lane = LW'(lane); phy_rdbk = DW'(rd);
      fv = rd + (model_diff[lane] & 'h1E0) + 'h20;    // R7
      if (fv > 1023) fv = 1023;                       // R8
      base = st ? 0 : model_max;
      model_max = (fv > base) ? fv : base;            // R9
      fin_q.push_back('{lane: LW'(lane), fin: DW'(fv), mx: DW'(model_max)});
   endtask

   task automatic idle();
      @(negedge clk);
      seed_vld = 1'b0; fin_vld = 1'b0; fin_start = 1'b0;
   endtask

   // Monitor: results are due on the falling edge after the capturing rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (seed_out_vld) begin
            if (seed_q.size() == 0) chk("R6 unexpected seed result", 1, 0);
            else begin
               seed_exp_t e;
               e = seed_q.pop_front();
               chk("R6 seed lane", int'(seed_out_lane), int'(e.lane));
               chk("R4 phy_seed", int'(phy_seed), int'(e.seed));
               chk("R3 rcven_init", int'(rcven_init), int'(e.init));
               chk("R5 gross_diff", int'(gross_diff), int'(e.diff));
            end
         end
         if (fin_out_vld) begin
            if (fin_q.size() == 0) chk("R7 unexpected final result", 1, 0);
            else begin
               fin_exp_t e;
               e = fin_q.pop_front();
               chk("R7 final lane", int'(fin_out_lane), int'(e.lane));
               chk("R7 R8 final_dly", int'(final_dly), int'(e.fin));
               chk("R9 max_dly", int'(max_dly), int'(e.mx));
            end
         end
      end
   end

   initial begin
      #2_000_000;
      chk("watchdog expired", 1, 0);
      summary();
   end

   initial begin
      foreach (model_diff[i]) model_diff[i] = 0;
      model_max = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 seed_out_vld after reset", int'(seed_out_vld), 0);
      chk("R10 fin_out_vld after reset", int'(fin_out_vld), 0);
      chk("R10 max_dly after reset", int'(max_dly), 0);
      // R10: unseeded lane finalizes to readback plus one UI
      drive_fin(7, 100, 1'b1);
      idle();
      idle();

      // Seed pass, back to back
      drive_seed(0, 'h40, 'h3B, 1'b0, 0);     // R1: gross 3 odd
      drive_seed(1, 5, 3, 1'b0, 0);           // R5: gross 0, gap floored
      drive_seed(2, 'h60, 'h20, 1'b0, 'h3FF); // R2: override ignored, gross 4 even
      drive_seed(3, 'h50, 'h3B, 1'b1, 'h10);  // R2: override used
      drive_seed(4, 1000, 100, 1'b0, 0);      // R1: clamp to 1023
      drive_seed(5, 600, 40, 1'b0, 0);        // gross 20: masked gap
      drive_seed(6, 33, 0, 1'b0, 0);          // gross 1 odd, gap 0
      drive_seed(7, 200, 'h3B, 1'b1, 300);
      idle();
      idle();

      // Finalize pass
      drive_fin(0, 59, 1'b1);
      drive_fin(1, 40, 1'b0);
      drive_fin(2, 70, 1'b0);
      drive_fin(3, 1000, 1'b0);               // R8: saturates
      drive_fin(4, 90, 1'b0);
      drive_fin(5, 75, 1'b0);
      drive_fin(6, 33, 1'b0);
      drive_fin(7, 120, 1'b0);
      idle();
      idle();

      // R9: a start pulse alone clears the maximum
      @(negedge clk);
      fin_start = 1'b1;
      @(negedge clk);
      fin_start = 1'b0;
      chk("R9 max_dly cleared by fin_start", int'(max_dly), 0);
      model_max = 0;

      // R11: reseed lane 2 only, then lane 3 must still use its old gap
      drive_seed(2, 900, 0, 1'b0, 0);
      drive_fin(3, 10, 1'b0);
      drive_fin(2, 10, 1'b0);
      drive_fin(1, 5, 1'b1);                  // R9: new pass starts from this lane
      drive_fin(0, 200, 1'b0);
      idle();
      idle();
      idle();

      chk("R6 seed results all delivered", seed_q.size(), 0);
      chk("R7 final results all delivered", fin_q.size(), 0);
      summary();
   end
endmodule